// File: doc/BRIEF.md
# Zero-Cross Mute Arbiter

This block decides, for each stereo side of an audio output stage, whether that side is silenced. Its mute sources have a fixed priority order. An active-low hardware pin ranks first and silences every output. A software immediate-mute flag ranks next and also silences every output at once. Last comes a zero-cross mute request, which silences or restores each side only when that side's external detector reports a signal zero crossing. A side is also silenced when no audio source is selected.

Each side (left = index 0, right = index 1) keeps its own zero-cross state. That state follows the current zero-cross request at that side's crossing strobe and at no other time. If the request toggles before a crossing arrives, the pending change simply follows the new request. A status flag reports when both sides agree with the request: 1 when both are silenced under an active request, and 0 when both have been restored after it was withdrawn. Each `ch_mute` bit drives the mute switches of both outputs (front and rear) on its side.

Top module: `zc_mute_arbiter`

## Requirements
- R1: While `hw_mute_n` is 0, both `ch_mute` bits are 1 from the next clock cycle, regardless of every other input.
- R2: While `imm_mute` is 1, both `ch_mute` bits are 1 from the next clock cycle, regardless of the zero-cross state.
- R3: When all `src_sel` bits are 0, both `ch_mute` bits are 1 from the next clock cycle. Any single set bit counts as a selected source.
- R4: With `zc_mute` at 1, a side goes silent in the cycle after its own `zc_pulse` bit (bit 0 left, bit 1 right) is high, and not before. The other side is unaffected.
- R5: With `zc_mute` at 0, a silenced side is restored in the cycle after its own `zc_pulse` bit is high, and not before, provided no forcing source (R1 to R3) is active.
- R6: `zcs` becomes 1 in the cycle in which both sides are silent under `zc_mute`=1. It becomes 0 in the cycle in which both sides are restored under `zc_mute`=0.
- R7: If `zc_mute` toggles before a side's crossing, that side's pending change targets the latest request. A side without a crossing keeps its state. `zcs` holds its value while the sides disagree with each other or with the request.
- R8: Under reset (`rst`=1), both `ch_mute` bits and `zcs` are 0 from the next clock edge.
- R9: Crossings that arrive while R1 or R2 forces silence still update the zero-cross state and `zcs`. The outputs show this state once the forcing source is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_mute_n | input | 1 | Hardware mute pin, 0 silences all outputs |
| imm_mute | input | 1 | Software immediate-mute flag |
| zc_mute | input | 1 | Zero-cross mute request |
| src_sel | input | NUM_SRC (3) | Audio source select bits |
| zc_pulse | input | NUM_CH (2) | Single-cycle zero-crossing strobes, bit 0 left |
| ch_mute | output | NUM_CH (2) | Per-side mute control, bit 0 left |
| zcs | output | 1 | Zero-cross completion status |

## Verification
The bench builds the block with its default values, two sides and three source bits. This setting gives real left/right independence: one side can sit silenced while the other still waits for its crossing, which is the mixed state that R7 depends on. With three source bits, both the all-clear case and a lone set bit in the highest position can be exercised.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

    // Zero-cross state of one output side
    typedef enum logic {
        CH_PLAY   = 1'b0,
        CH_SILENT = 1'b1
    } ch_state_e;

    // Sources that silence every output without waiting for a crossing
    typedef struct packed {
        logic pin;
        logic imm;
        logic nosrc;
    } force_src_t;

    function automatic logic force_active(input force_src_t f);
        return f.pin | f.imm | f.nosrc;
    endfunction

endpackage

// File: rtl/zcm_force_gen.sv
module zcm_force_gen
    import zcm_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               hw_mute_n,
    input  logic               imm_mute,
    input  logic [NUM_SRC-1:0] src_sel,
    output force_src_t         srcs_o,
    output logic               force_o
);

    always_comb begin
        srcs_o.pin   = ~hw_mute_n;
        srcs_o.imm   = imm_mute;
        srcs_o.nosrc = ~|src_sel;
        force_o      = force_active(srcs_o);
    end

endmodule

// File: rtl/zcm_chan_track.sv
module zcm_chan_track
    import zcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      force_i,
    input  ch_state_e req_i,
    input  logic      pulse_i,
    output ch_state_e state_o,
    output ch_state_e state_nxt_o,
    output logic      mute_o
);

    ch_state_e state_q;
    logic      mute_q;

    // The side's state moves only at its own crossing strobe
    always_comb begin
        state_nxt_o = pulse_i ? req_i : state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_PLAY;
            mute_q  <= 1'b0;
        end else begin
            state_q <= state_nxt_o;
            mute_q  <= force_i | (state_nxt_o == CH_SILENT);
        end
    end

    assign state_o = state_q;
    assign mute_o  = mute_q;

    // R4: a crossing under an active request silences this side
    p_zc_mute_r4: assert property (@(posedge clk) disable iff (rst)
        (pulse_i && req_i == CH_SILENT) |=> mute_o);

    // R5: a crossing under a withdrawn request restores this side
    p_zc_unmute_r5: assert property (@(posedge clk) disable iff (rst)
        (pulse_i && req_i == CH_PLAY && !force_i) |=> !mute_o);

    // R7: without a crossing the side keeps its state
    p_zc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !pulse_i |=> $stable(state_q));

    // R7: a crossing lands on the latest request
    p_zc_retarget_r7: assert property (@(posedge clk) disable iff (rst)
        pulse_i |=> (state_q == $past(req_i)));

endmodule

// File: rtl/zcm_status.sv
module zcm_status #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [NUM_CH-1:0] silent_nxt_i,
    input  logic [NUM_CH-1:0] silent_q_i,
    output logic              zcs_o
);

    logic all_match;
    logic zcs_q;

    always_comb begin
        all_match = req_i ? (&silent_nxt_i) : ~|silent_nxt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zcs_q <= 1'b0;
        end else if (all_match) begin
            zcs_q <= req_i;
        end
    end

    assign zcs_o = zcs_q;

    // R6: status rises only with every side silent
    p_zcs_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(zcs_o) |-> (&silent_q_i));

    // R6: status falls only with every side restored
    p_zcs_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(zcs_o) |-> (~|silent_q_i));

    // R7: status holds while the sides disagree
    p_zcs_mixed_r7: assert property (@(posedge clk) disable iff (rst)
        (|silent_q_i && !(&silent_q_i)) |-> $stable(zcs_o));

endmodule

// File: rtl/zc_mute_arbiter.sv
module zc_mute_arbiter
    import zcm_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hw_mute_n,
    input  logic               imm_mute,
    input  logic               zc_mute,
    input  logic [NUM_SRC-1:0] src_sel,
    input  logic [NUM_CH-1:0]  zc_pulse,
    output logic [NUM_CH-1:0]  ch_mute,
    output logic               zcs
);

    localparam logic [NUM_CH-1:0] ALL_MUTED = {NUM_CH{1'b1}};

    force_src_t        srcs;
    logic              force_any;
    ch_state_e         req;
    logic [NUM_CH-1:0] silent_q;
    logic [NUM_CH-1:0] silent_nxt;

    assign req = zc_mute ? CH_SILENT : CH_PLAY;

    zcm_force_gen #(.NUM_SRC(NUM_SRC)) u_force (
        .hw_mute_n (hw_mute_n),
        .imm_mute  (imm_mute),
        .src_sel   (src_sel),
        .srcs_o    (srcs),
        .force_o   (force_any)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ch_state_e st_q;
        ch_state_e st_nxt;

        zcm_chan_track u_track (
            .clk         (clk),
            .rst         (rst),
            .force_i     (force_any),
            .req_i       (req),
            .pulse_i     (zc_pulse[c]),
            .state_o     (st_q),
            .state_nxt_o (st_nxt),
            .mute_o      (ch_mute[c])
        );

        assign silent_q[c]   = (st_q == CH_SILENT);
        assign silent_nxt[c] = (st_nxt == CH_SILENT);
    end

    zcm_status #(.NUM_CH(NUM_CH)) u_status (
        .clk          (clk),
        .rst          (rst),
        .req_i        (zc_mute),
        .silent_nxt_i (silent_nxt),
        .silent_q_i   (silent_q),
        .zcs_o        (zcs)
    );

    // R1: hardware pin silences every side next cycle
    p_pin_mute_r1: assert property (@(posedge clk) disable iff (rst)
        !hw_mute_n |=> (ch_mute == ALL_MUTED));

    // R2: immediate flag silences every side next cycle
    p_imm_mute_r2: assert property (@(posedge clk) disable iff (rst)
        imm_mute |=> (ch_mute == ALL_MUTED));

    // R3: no source selected silences every side
    p_no_source_r3: assert property (@(posedge clk) disable iff (rst)
        (src_sel == '0) |=> (ch_mute == ALL_MUTED));

    // R8: reset clears outputs and status
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (ch_mute == '0 && !zcs));

    // R9: without forcing, each output follows its side's state
    p_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (!force_any && !$past(force_any)) |-> (ch_mute == silent_q));

    // R1, R2: the forcing flags reach the arbiter unmodified
    p_force_map_r1: assert property (@(posedge clk)
        (srcs.pin == !hw_mute_n) && (srcs.imm == imm_mute));

endmodule

// File: tb/zc_mute_arbiter_tb.sv
module zc_mute_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       hw_mute_n;
    logic       imm_mute;
    logic       zc_mute;
    logic [2:0] src_sel;
    logic [1:0] zc_pulse;
    logic [1:0] ch_mute;
    logic       zcs;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    zc_mute_arbiter u_dut (
        .clk       (clk),
        .rst       (rst),
        .hw_mute_n (hw_mute_n),
        .imm_mute  (imm_mute),
        .zc_mute   (zc_mute),
        .src_sel   (src_sel),
        .zc_pulse  (zc_pulse),
        .ch_mute   (ch_mute),
        .zcs       (zcs)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input logic [1:0] mask);
        zc_pulse = mask;
        step();
        zc_pulse = 2'b00;
    endtask

    task automatic t_reset();
        rst = 1'b1; hw_mute_n = 1'b1; imm_mute = 1'b0; zc_mute = 1'b0;
        src_sel = 3'b001; zc_pulse = 2'b00;
        step(3);
        chk("R8 mute in reset", {6'd0, ch_mute}, 8'h0);
        chk("R8 zcs in reset", {7'd0, zcs}, 8'h0);
        rst = 1'b0;
        step(2);
        chk("R8 mute after reset", {6'd0, ch_mute}, 8'h0);
    endtask

    task automatic t_pin_mute();
        hw_mute_n = 1'b0; step();
        chk("R1 pin low", {6'd0, ch_mute}, 8'h3);
        hw_mute_n = 1'b1; step();
        chk("R1 pin released", {6'd0, ch_mute}, 8'h0);
    endtask

    task automatic t_imm_mute();
        imm_mute = 1'b1; step();
        chk("R2 imm set", {6'd0, ch_mute}, 8'h3);
        imm_mute = 1'b0; step();
        chk("R2 imm clear", {6'd0, ch_mute}, 8'h0);
    endtask

    task automatic t_no_source();
        src_sel = 3'b000; step();
        chk("R3 no source", {6'd0, ch_mute}, 8'h3);
        src_sel = 3'b100; step();
        chk("R3 top source only", {6'd0, ch_mute}, 8'h0);
        src_sel = 3'b001;
    endtask

    task automatic t_zc_mute();
        zc_mute = 1'b1; step(2);
        chk("R4 waits for crossing", {6'd0, ch_mute}, 8'h0);
        chk("R6 zcs before crossings", {7'd0, zcs}, 8'h0);
        strobe(2'b01);
        chk("R4 left silenced only", {6'd0, ch_mute}, 8'h1);
        chk("R6 zcs one side", {7'd0, zcs}, 8'h0);
        step(2);
        chk("R4 right still waits", {6'd0, ch_mute}, 8'h1);
        strobe(2'b10);
        chk("R4 right silenced", {6'd0, ch_mute}, 8'h3);
        chk("R6 zcs both silent", {7'd0, zcs}, 8'h1);
    endtask

    task automatic t_zc_unmute();
        zc_mute = 1'b0; step(2);
        chk("R5 waits for crossing", {6'd0, ch_mute}, 8'h3);
        chk("R6 zcs holds during wait", {7'd0, zcs}, 8'h1);
        strobe(2'b10);
        chk("R5 right restored only", {6'd0, ch_mute}, 8'h1);
        chk("R6 zcs with left still off", {7'd0, zcs}, 8'h1);
        strobe(2'b01);
        chk("R5 left restored", {6'd0, ch_mute}, 8'h0);
        chk("R6 zcs both restored", {7'd0, zcs}, 8'h0);
    endtask

    task automatic t_retarget();
        zc_mute = 1'b1; step();
        strobe(2'b01);
        chk("R7 left silenced", {6'd0, ch_mute}, 8'h1);
        zc_mute = 1'b0; step();
        strobe(2'b10);
        chk("R7 right follows new request", {6'd0, ch_mute}, 8'h1);
        chk("R7 zcs holds when mixed", {7'd0, zcs}, 8'h0);
        strobe(2'b01);
        chk("R7 left retargeted to play", {6'd0, ch_mute}, 8'h0);
        zc_mute = 1'b1; step();
        strobe(2'b11);
        chk("R7 both silenced together", {6'd0, ch_mute}, 8'h3);
        chk("R6 zcs simultaneous", {7'd0, zcs}, 8'h1);
        zc_mute = 1'b0; step();
        zc_mute = 1'b1; step();
        strobe(2'b01);
        chk("R7 toggle cancelled", {6'd0, ch_mute}, 8'h3);
        chk("R7 zcs kept", {7'd0, zcs}, 8'h1);
        zc_mute = 1'b0; step();
        strobe(2'b11);
        chk("R5 both restored", {6'd0, ch_mute}, 8'h0);
        chk("R6 zcs cleared", {7'd0, zcs}, 8'h0);
    endtask

    task automatic t_force_over_zc();
        zc_mute = 1'b1; imm_mute = 1'b1; step();
        strobe(2'b11);
        chk("R2 imm during crossings", {6'd0, ch_mute}, 8'h3);
        chk("R9 zcs tracks under imm", {7'd0, zcs}, 8'h1);
        imm_mute = 1'b0; step();
        chk("R9 state kept after imm", {6'd0, ch_mute}, 8'h3);
        zc_mute = 1'b0; hw_mute_n = 1'b0; step();
        strobe(2'b11);
        chk("R1 pin over restore", {6'd0, ch_mute}, 8'h3);
        chk("R9 zcs clears under pin", {7'd0, zcs}, 8'h0);
        hw_mute_n = 1'b1; step();
        chk("R9 restored after pin", {6'd0, ch_mute}, 8'h0);
        imm_mute = 1'b1; step();
        chk("R2 imm with zc idle", {6'd0, ch_mute}, 8'h3);
        chk("R2 imm leaves zcs", {7'd0, zcs}, 8'h0);
        imm_mute = 1'b0; step();
    endtask

    initial begin
        t_reset();
        t_pin_mute();
        t_imm_mute();
        t_no_source();
        t_zc_mute();
        t_zc_unmute();
        t_retarget();
        t_force_over_zc();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule